// File: doc/BRIEF.md
# Misaligned External Bus Access Sequencer

This block sits between a CPU-side data request port and an external memory bus. The external bus has a 16-bit data path and a 24-bit byte address. A request carries a size of one, two or four bytes and may start at any byte address. The block turns each request into one, two or three external bus cycles. For every cycle it drives the address, the active-low read strobe or the active-low per-lane write strobes, and the write data, placed on the correct byte lane.

Bytes at even addresses use the low half of the external data path, and bytes at odd addresses use the high half. On reads, the block gathers the returned bytes into a 32-bit result. The byte at the lowest address becomes the least significant byte. Bytes that arrive on a lane the current cycle does not use are discarded.

Each external cycle takes two clocks: an address setup clock followed by a strobe clock. Wait states, recovery time, burst access and an 8-bit bus are not supported.

Top module: `xbs_bus_seq`

## Requirements
- R1: When idle, `req_ack` is high in the same cycle as `req_valid`, and that edge accepts the request. While a request is in progress, `req_ack` stays low. `req_done` is a single-cycle pulse in the clock after the final strobe clock, so it appears 2N+1 clocks after the accepting edge for a request of N bus cycles. After reset, `req_ack`, `req_done` and `ext_oe` are low, all strobes are high and `req_rdata` is zero.
- R2: Every bus cycle is one setup clock followed by one strobe clock. In the setup clock all strobes are high. `ext_addr` keeps the same value over both clocks. `ext_rd_n` goes low only in the strobe clock of a read, and never together with a write strobe.
- R3: A byte at an even address travels on `ext_dout`/`ext_din` bits [7:0], and a byte at an odd address on bits [15:8]. In a write strobe clock, `ext_wrl_n` is low only if bits [7:0] carry a requested byte, and `ext_wrh_n` only if bits [15:8] do.
- R4: A one-byte request (size code 0) takes exactly one bus cycle at its own address, on the single lane that its address selects.
- R5: A two-byte request (size code 1) at an even address is one cycle at A using both lanes. At an odd address it is two cycles: A on the high lane, then A+1 on the low lane.
- R6: A four-byte request at an even address is two cycles, A and A+2, each using both lanes.
- R7: A four-byte request at an odd address is three cycles. The first is at A on the high lane, the second at A+1 on both lanes, and the third at A+3 on the low lane.
- R8: The read result is little-endian, and bytes above the request size read as zero. A byte on a lane the cycle does not use is never stored.
- R9: `req_rdata` holds its value from the `req_done` pulse until the next request is accepted.
- R10: Addresses of later cycles wrap modulo 2^24. For example, a four-byte request at FFFFFF uses FFFFFF, 000000 and 000002.
- R11: Size code 3 behaves as a four-byte request.
- R12: `ext_oe` is high over both clocks of a write cycle and low otherwise. `ext_dout` carries zero on lanes a cycle does not use and during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ack | output | 1 | Request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 two bytes, 2 or 3 four bytes |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data, lowest address in bits [7:0] |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Assembled read data |
| ext_addr | output | 24 | External address |
| ext_dout | output | 16 | External write data |
| ext_oe | output | 1 | Write data drive enable |
| ext_din | input | 16 | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wrl_n | output | 1 | Low-lane write strobe, active low |
| ext_wrh_n | output | 1 | High-lane write strobe, active low |

## Verification
The assertions check the bus protocol on every clock. They cover the setup clock before each strobe, a stable address across the cycle, read and write strobes never overlapping, a one-clock `req_done` pulse that follows a strobe clock, output enable during writes, and adjacent byte indices when both lanes are captured. The cycle sequences for each size and alignment, the lane and strobe selection, the wrap at the top of the address space and the assembled read values can only be shown by the bench scenarios. There, a model memory puts unrelated bytes on the unused lane, which the result must not contain.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int XBS_DATA_W = 32;
  localparam int XBS_LANE_W = 8;
  localparam int XBS_NBYTES = XBS_DATA_W / XBS_LANE_W;
  localparam int XBS_IDX_W  = $clog2(XBS_NBYTES);

  typedef enum logic [1:0] {
    XBS_SZ_BYTE   = 2'd0,
    XBS_SZ_HALF   = 2'd1,
    XBS_SZ_WORD   = 2'd2,
    XBS_SZ_WORD_X = 2'd3
  } xbs_size_e;

  typedef enum logic [1:0] {
    XBS_IDLE   = 2'd0,
    XBS_SETUP  = 2'd1,
    XBS_STROBE = 2'd2
  } xbs_state_e;

  // byte lane usage of one bus cycle and which request byte each lane carries
  typedef struct packed {
    logic                 lo_en;
    logic                 hi_en;
    logic [XBS_IDX_W-1:0] lo_idx;
    logic [XBS_IDX_W-1:0] hi_idx;
  } xbs_lanes_t;
endpackage

// File: rtl/xbs_cycle_plan.sv
module xbs_cycle_plan
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CYC_W  = 2
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  xbs_size_e         size,
  input  logic [CYC_W-1:0]  cyc_idx,
  output logic [ADDR_W-1:0] cyc_addr,
  output xbs_lanes_t        lanes,
  output logic              cyc_last
);
  localparam int POS_W = CYC_W + 2;

  logic [POS_W-1:0]  nbytes;
  logic [POS_W-1:0]  ncyc;
  logic [POS_W-1:0]  two_j;
  logic [POS_W-1:0]  odd_off;
  logic [POS_W-1:0]  lo_pos;
  logic [POS_W-1:0]  hi_pos;
  logic [ADDR_W-1:0] even_base;

  always_comb begin
    unique case (size)
      XBS_SZ_BYTE: nbytes = POS_W'(1);
      XBS_SZ_HALF: nbytes = POS_W'(2);
      default:     nbytes = POS_W'(XBS_NBYTES);
    endcase
    odd_off  = POS_W'(base_addr[0]);
    two_j    = POS_W'(cyc_idx) << 1;
    ncyc     = (odd_off + nbytes + POS_W'(1)) >> 1;
    cyc_last = (POS_W'(cyc_idx) == (ncyc - POS_W'(1)));
    // position of the byte on each lane relative to the first request byte
    lo_pos   = two_j - odd_off;
    hi_pos   = two_j + POS_W'(1) - odd_off;
    lanes.lo_en  = (lo_pos < nbytes);
    lanes.hi_en  = (hi_pos < nbytes);
    lanes.lo_idx = lo_pos[XBS_IDX_W-1:0];
    lanes.hi_idx = hi_pos[XBS_IDX_W-1:0];
    even_base = {base_addr[ADDR_W-1:1], 1'b0};
    if (cyc_idx == '0) cyc_addr = base_addr;
    else               cyc_addr = even_base + (ADDR_W'(cyc_idx) << 1);
  end
endmodule

// File: rtl/xbs_wr_steer.sv
module xbs_wr_steer
  import xbs_pkg::*;
(
  input  logic [XBS_DATA_W-1:0]   wdata,
  input  xbs_lanes_t              lanes,
  input  logic                    drive,
  output logic [2*XBS_LANE_W-1:0] dout
);
  always_comb begin
    dout = '0;
    if (drive && lanes.lo_en)
      dout[XBS_LANE_W-1:0] = wdata[lanes.lo_idx*XBS_LANE_W +: XBS_LANE_W];
    if (drive && lanes.hi_en)
      dout[2*XBS_LANE_W-1:XBS_LANE_W] = wdata[lanes.hi_idx*XBS_LANE_W +: XBS_LANE_W];
  end
endmodule

// File: rtl/xbs_rd_gather.sv
module xbs_rd_gather
  import xbs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    capture,
  input  xbs_lanes_t              lanes,
  input  logic [2*XBS_LANE_W-1:0] din,
  output logic [XBS_DATA_W-1:0]   rdata
);
  logic upd;
  assign upd = clear | capture;

  for (genvar b = 0; b < XBS_NBYTES; b++) begin : g_byte
    logic [XBS_LANE_W-1:0] cur_q;
    logic [XBS_LANE_W-1:0] nxt;

    always_comb begin
      nxt = cur_q;
      if (clear)
        nxt = '0;
      else if (capture && lanes.lo_en && (lanes.lo_idx == XBS_IDX_W'(b)))
        nxt = din[XBS_LANE_W-1:0];
      else if (capture && lanes.hi_en && (lanes.hi_idx == XBS_IDX_W'(b)))
        nxt = din[2*XBS_LANE_W-1:XBS_LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur_q <= '0;
      else if (upd) cur_q <= nxt;
    end

    assign rdata[b*XBS_LANE_W +: XBS_LANE_W] = cur_q;
  end

  AST_LANE_IDX_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && lanes.lo_en && lanes.hi_en) |-> (lanes.hi_idx == lanes.lo_idx + XBS_IDX_W'(1))); // R8
  AST_CLEAR_NOT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && capture)); // R1
endmodule

// File: rtl/xbs_bus_seq.sv
module xbs_bus_seq
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ack,
  input  logic                    req_write,
  input  logic [1:0]              req_size,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [XBS_DATA_W-1:0]   req_wdata,
  output logic                    req_done,
  output logic [XBS_DATA_W-1:0]   req_rdata,
  output logic [ADDR_W-1:0]       ext_addr,
  output logic [2*XBS_LANE_W-1:0] ext_dout,
  output logic                    ext_oe,
  input  logic [2*XBS_LANE_W-1:0] ext_din,
  output logic                    ext_rd_n,
  output logic                    ext_wrl_n,
  output logic                    ext_wrh_n
);
  localparam int CYC_W = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  xbs_state_e            st_q, st_d;
  logic [CYC_W-1:0]      cyc_q, cyc_d;
  logic                  done_q, done_d;
  logic [ADDR_W-1:0]     addr_q;
  xbs_size_e             size_q;
  logic                  wr_q;
  logic [XBS_DATA_W-1:0] wdata_q;
  logic                  accept;
  logic                  busy;
  logic                  strobe_ph;
  logic [ADDR_W-1:0]     cyc_addr;
  xbs_lanes_t            lanes;
  logic                  cyc_last;
  logic [2*XBS_LANE_W-1:0] steer_dout;

  assign accept    = (st_q == XBS_IDLE) && req_valid;
  assign busy      = (st_q != XBS_IDLE);
  assign strobe_ph = (st_q == XBS_STROBE);

  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    done_d = 1'b0;
    unique case (st_q)
      XBS_IDLE: begin
        if (req_valid) begin
          st_d  = XBS_SETUP;
          cyc_d = '0;
        end
      end
      XBS_SETUP: st_d = XBS_STROBE;
      XBS_STROBE: begin
        if (cyc_last) begin
          st_d   = XBS_IDLE;
          done_d = 1'b1;
        end else begin
          st_d  = XBS_SETUP;
          cyc_d = cyc_q + CYC_W'(1);
        end
      end
      default: st_d = XBS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      st_q   <= XBS_IDLE;
      cyc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cyc_q  <= cyc_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      addr_q  <= '0;
      size_q  <= XBS_SZ_BYTE;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      size_q  <= xbs_size_e'(req_size);
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  xbs_cycle_plan #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_plan (
    .base_addr (addr_q),
    .size      (size_q),
    .cyc_idx   (cyc_q),
    .cyc_addr  (cyc_addr),
    .lanes     (lanes),
    .cyc_last  (cyc_last)
  );

  xbs_wr_steer u_steer (
    .wdata (wdata_q),
    .lanes (lanes),
    .drive (busy && wr_q),
    .dout  (steer_dout)
  );

  xbs_rd_gather u_gather (
    .clk     (clk),
    .rst_n   (rst_n_q),
    .clear   (accept),
    .capture (strobe_ph && !wr_q),
    .lanes   (lanes),
    .din     (ext_din),
    .rdata   (req_rdata)
  );

  assign req_ack   = accept;
  assign req_done  = done_q;
  assign ext_addr  = busy ? cyc_addr : '0;
  assign ext_dout  = steer_dout;
  assign ext_oe    = busy && wr_q;
  assign ext_rd_n  = !(strobe_ph && !wr_q);
  assign ext_wrl_n = !(strobe_ph && wr_q && lanes.lo_en);
  assign ext_wrh_n = !(strobe_ph && wr_q && lanes.hi_en);

  logic strb_any;
  assign strb_any = !ext_rd_n || !ext_wrl_n || !ext_wrh_n;

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_q)
    !(!ext_rd_n && (!ext_wrl_n || !ext_wrh_n))); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n_q)
    strb_any |-> $stable(ext_addr)); // R2
  AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n_q)
    strb_any |-> $past(!strb_any)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    req_done |=> !req_done); // R1
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n_q)
    req_done |-> $past(strb_any)); // R1
  AST_NO_ACK_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n_q)
    ext_oe |-> !req_ack); // R1
  AST_WRITE_HAS_OE: assert property (@(posedge clk) disable iff (!rst_n_q)
    (!ext_wrl_n || !ext_wrh_n) |-> ext_oe); // R12
endmodule

// File: tb/xbs_bus_seq_tb_top.sv
module xbs_bus_seq_tb_top;
  import xbs_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ack, req_write, req_done;
  logic [1:0]  req_size;
  logic [23:0] req_addr, ext_addr;
  logic [31:0] req_wdata, req_rdata;
  logic [15:0] ext_dout, ext_din;
  logic        ext_oe, ext_rd_n, ext_wrl_n, ext_wrh_n;

  always #2 clk = ~clk;

  xbs_bus_seq #(.ADDR_W(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_oe(ext_oe), .ext_din(ext_din),
    .ext_rd_n(ext_rd_n), .ext_wrl_n(ext_wrl_n), .ext_wrh_n(ext_wrh_n)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;

  typedef struct {
    logic [23:0] addr;
    logic        wr;
    logic        lo;
    logic        hi;
    logic [15:0] dout;
  } cyc_t;
  typedef struct {
    logic        rd;
    logic [31:0] data;
  } res_t;
  cyc_t cq[$];
  res_t rq[$];

  // model memory: every address returns its own distinct byte
  function automatic logic [7:0] mem_b(logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction
  assign ext_din = {mem_b(ext_addr | 24'd1), mem_b(ext_addr & ~24'd1)};

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_cyc(logic [23:0] a, logic wr, logic lo, logic hi,
                          logic [7:0] lob, logic [7:0] hib);
    logic [15:0] d;
    d = wr ? {hi ? hib : 8'h00, lo ? lob : 8'h00} : 16'h0000;
    cq.push_back('{a, wr, lo, hi, d});
  endtask

  task automatic do_req(logic wr, logic [1:0] sz, logic [23:0] a, logic [31:0] wd, string tag);
    int          ncyc;
    int          cnt;
    logic [7:0]  b [4];
    logic [31:0] exp_rd;
    logic [31:0] held;
    for (int k = 0; k < 4; k++) b[k] = wr ? wd[8*k +: 8] : mem_b(a + 24'(k));
    case ({sz, a[0]})
      3'b000: begin push_cyc(a, wr, 1, 0, b[0], 0); ncyc = 1; exp_rd = {24'h0, b[0]}; end
      3'b001: begin push_cyc(a, wr, 0, 1, 0, b[0]); ncyc = 1; exp_rd = {24'h0, b[0]}; end
      3'b010: begin push_cyc(a, wr, 1, 1, b[0], b[1]); ncyc = 1; exp_rd = {16'h0, b[1], b[0]}; end
      3'b011: begin
        push_cyc(a, wr, 0, 1, 0, b[0]);
        push_cyc(a + 24'd1, wr, 1, 0, b[1], 0);
        ncyc = 2; exp_rd = {16'h0, b[1], b[0]};
      end
      default: begin
        exp_rd = {b[3], b[2], b[1], b[0]};
        if (!a[0]) begin
          push_cyc(a, wr, 1, 1, b[0], b[1]);
          push_cyc(a + 24'd2, wr, 1, 1, b[2], b[3]);
          ncyc = 2;
        end else begin
          push_cyc(a, wr, 0, 1, 0, b[0]);
          push_cyc(a + 24'd1, wr, 1, 1, b[1], b[2]);
          push_cyc(a + 24'd3, wr, 1, 0, b[3], 0);
          ncyc = 3;
        end
      end
    endcase
    rq.push_back('{!wr, exp_rd});

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    #1;
    chk(req_ack == 1'b1, {"R1 ack when idle ", tag}, {31'h0, req_ack}, 1);
    @(negedge clk);
    chk(req_ack == 1'b0, {"R1 no ack while busy ", tag}, {31'h0, req_ack}, 0);
    req_valid = 1'b0;
    req_wdata = 32'hDEAD_BEEF;
    cnt = 1;
    while (req_done !== 1'b1 && cnt < 16) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == 2*ncyc + 1, {"R1 done timing ", tag}, cnt, 2*ncyc + 1);
    held = req_rdata;
    repeat (3) @(negedge clk);
    chk(req_rdata == held, {"R9 result held ", tag}, req_rdata, held);
    chk(ext_oe == 1'b0 && ext_rd_n && ext_wrl_n && ext_wrh_n,
        {"R12 idle bus ", tag}, {28'h0, ext_oe, ext_rd_n, ext_wrl_n, ext_wrh_n}, 32'h7);
  endtask

  // monitor: compares every strobe clock and every completion with the queues
  logic        prev_strb;
  logic [23:0] prev_addr;
  always @(negedge clk) begin
    logic strb;
    cyc_t e;
    res_t r;
    strb = !ext_rd_n || !ext_wrl_n || !ext_wrh_n;
    if (mon_on) begin
      if (strb) begin
        if (cq.size() == 0) chk(0, "R2 unexpected bus cycle", {8'h0, ext_addr}, 0);
        else begin
          e = cq.pop_front();
          chk(ext_addr == e.addr, "R3 cycle address", {8'h0, ext_addr}, {8'h0, e.addr});
          chk(ext_rd_n == e.wr, "R2 read strobe", {31'h0, ext_rd_n}, {31'h0, e.wr});
          chk(ext_wrl_n == !(e.wr && e.lo), "R3 low write strobe", {31'h0, ext_wrl_n}, {31'h0, !(e.wr && e.lo)});
          chk(ext_wrh_n == !(e.wr && e.hi), "R3 high write strobe", {31'h0, ext_wrh_n}, {31'h0, !(e.wr && e.hi)});
          chk(ext_dout == e.dout, "R12 write data lanes", {16'h0, ext_dout}, {16'h0, e.dout});
          chk(ext_oe == e.wr, "R12 output enable", {31'h0, ext_oe}, {31'h0, e.wr});
          chk(!prev_strb && prev_addr == ext_addr, "R2 setup clock before strobe",
              {7'h0, prev_strb, prev_addr}, {8'h0, ext_addr});
        end
      end
      if (req_done) begin
        if (rq.size() == 0) chk(0, "R1 unexpected done", 1, 0);
        else begin
          r = rq.pop_front();
          if (r.rd) chk(req_rdata == r.data, "R8 assembled read data", req_rdata, r.data);
          chk(cq.size() == 0, "R4 all bus cycles issued before done", cq.size(), 0);
        end
      end
    end
    prev_strb = strb;
    prev_addr = ext_addr;
  end

  initial begin
    #(4 * 150000);
    chk(0, "watchdog expired", 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ack == 0 && req_done == 0 && ext_oe == 0 && ext_rd_n && ext_wrl_n && ext_wrh_n,
        "R1 reset state of controls", {26'h0, req_ack, req_done, ext_oe, ext_rd_n, ext_wrl_n, ext_wrh_n}, 32'h7);
    chk(req_rdata == 32'h0, "R1 reset read data", req_rdata, 0);
    mon_on = 1'b1;

    do_req(0, 2'd0, 24'h000100, 32'h0, "R4 byte even read");
    do_req(0, 2'd0, 24'h000101, 32'h0, "R4 byte odd read");
    do_req(1, 2'd0, 24'h000102, 32'h1122_3344, "R4 byte even write");
    do_req(1, 2'd0, 24'h000103, 32'h5566_7788, "R4 byte odd write");
    do_req(0, 2'd1, 24'h000110, 32'h0, "R5 half even read");
    do_req(1, 2'd1, 24'h000112, 32'hAABB_CCDD, "R5 half even write");
    do_req(0, 2'd1, 24'h000115, 32'h0, "R5 half odd read");
    do_req(1, 2'd1, 24'h000117, 32'h0102_0304, "R5 half odd write");
    do_req(0, 2'd2, 24'h000200, 32'h0, "R6 word even read");
    do_req(1, 2'd2, 24'h000204, 32'hCAFE_F00D, "R6 word even write");
    do_req(0, 2'd2, 24'h000201, 32'h0, "R7 word odd read");
    do_req(1, 2'd2, 24'h000203, 32'h8899_AABB, "R7 word odd write");
    do_req(0, 2'd0, 24'h000305, 32'h0, "R8 narrow read clears upper bytes");
    do_req(0, 2'd3, 24'h000301, 32'h0, "R11 size code 3 read");
    do_req(1, 2'd3, 24'h000306, 32'h1357_9BDF, "R11 size code 3 write");
    do_req(0, 2'd2, 24'hFFFFFF, 32'h0, "R10 word wrap read");
    do_req(1, 2'd1, 24'hFFFFFF, 32'hFFFF_5AA5, "R10 half wrap write");
    do_req(0, 2'd2, 24'hFFFFFE, 32'h0, "R10 word even wrap read");

    repeat (4) @(negedge clk);
    chk(cq.size() == 0 && rq.size() == 0, "R1 scoreboard drained", cq.size() + rq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule